// File: doc/BRIEF.md
# Configurable General-Purpose Pin Bank Controller

This block runs a bank of general-purpose pins. For each pin, software decides whether the pin belongs to software or is handed to an on-chip peripheral. A software-owned pin takes its direction and output level from registers. A peripheral-owned pin takes its output level and output enable from whichever peripheral the routing places on it. Every pin also has a pad pull setting (up, down or off) that is driven to the pad cell as two control lines.

Each peripheral brings a small group of signals. A per-peripheral location bit places that group on one of two alternative pin sets. When two peripherals land on the same pin, the lower-numbered peripheral gets it. Pad inputs pass through a two-flop synchroniser. The synchronised levels feed the peripherals, a register readback, and an edge detector. The edge detector raises sticky per-pin flags on the selected edge polarity, and these flags are combined into a single interrupt line.

Software reaches the block through a flat bank of eight registers, with a write strobe and a combinational read path. The analog pad cells stay outside the block and are seen only as output value, output enable and pull controls.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every register reads 0, no pad is driven (`pad_oe_o`=0, `pad_out_o`=0), no pull is active and `irq_o` is low.
- R2: A pin whose bit in the ownership register (address 2) is 0 is software-owned. Its `pad_oe_o` bit equals its bit in the direction register (address 1, 1 = output) and its `pad_out_o` bit equals its bit in the output latch (written at address 0).
- R3: The pull-enable register (address 3) and the pull-polarity register (address 4, 1 = up, 0 = down) give `pad_pu_o` = enable AND polarity and `pad_pd_o` = enable AND NOT polarity. The two are never both high on a pin.
- R4: Pad inputs are resynchronised by two flops. A read at address 0 returns the pad levels as they were two clock edges earlier, and so does `per_in_o`.
- R5: Bit 1+p of the control register (address 7) is the location of peripheral p. Signal s of peripheral p is at pin p*SIG_W+s for location 0 and at pin (p*SIG_W+s+ALT_SHIFT) mod NUM_PINS for location 1. `per_in_o[p*SIG_W+s]` follows that pin.
- R6: A pin whose ownership bit is 1 drives `per_out_i`/`per_oe_i` of the peripheral signal routed onto it. If no peripheral is routed there, the pin is not driven and outputs 0.
- R7: When two peripherals route onto the same pin, the lower-numbered peripheral drives it.
- R8: Bit 0 of the control register selects the edge (0 = rising, 1 = falling). A selected edge on a pin whose bit in the interrupt-enable register (address 5) is 1 sets that pin's flag on the third clock edge after the pad changes. Edges on disabled pins and edges of the other polarity set nothing.
- R9: Flags (read at address 6) are sticky. Writing 1 to a bit at address 6 clears that flag, and writing 0 leaves it unchanged. A new edge in the same cycle as a clear wins.
- R10: `irq_o` is high exactly when some flag is set and its interrupt-enable bit is 1. Clearing the enable masks the interrupt and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | NUM_PINS | Write data |
| reg_rdata_o | output | NUM_PINS | Read data for `reg_addr_i` (combinational) |
| pad_in_i | input | NUM_PINS | Raw pad input levels |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |
| pad_pu_o | output | NUM_PINS | Pull-up controls |
| pad_pd_o | output | NUM_PINS | Pull-down controls |
| per_out_i | input | NUM_PERIPH*SIG_W | Peripheral output values |
| per_oe_i | input | NUM_PERIPH*SIG_W | Peripheral output enables |
| per_in_o | output | NUM_PERIPH*SIG_W | Synchronised pin levels returned to peripherals |
| irq_o | output | 1 | Port interrupt |

## Verification
The bench uses the default parameters: NUM_PINS=8, NUM_PERIPH=2, SIG_W=2, ALT_SHIFT=2. With these values, location 1 of peripheral 0 overlaps location 0 of peripheral 1 on pins 2 and 3, so the lower-number priority rule can be reached. Pins 4 to 7 stay unclaimed unless peripheral 1 moves, which exercises the undriven case for peripheral-owned pins. Eight pins are few enough that random ownership, direction and location settings hit every mix of owners within a few dozen iterations.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    typedef enum logic [2:0] {
        A_DOUT = 3'd0,
        A_DIR  = 3'd1,
        A_FUNC = 3'd2,
        A_PEN  = 3'd3,
        A_PSEL = 3'd4,
        A_IEN  = 3'd5,
        A_FLAG = 3'd6,
        A_CTRL = 3'd7
    } reg_addr_e;

    // Pin index of signal s of peripheral p for a given location bit.
    function automatic int route_pin(int p, int s, logic loc, int sig_w, int shift, int npins);
        int base;
        base = p * sig_w + s;
        return loc ? ((base + shift) % npins) : base;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/pinbank_edge.sv
module pinbank_edge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic         fall_i,
    input  logic [W-1:0] ien_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] prev_q;
    logic [W-1:0] flag_q;
    logic [W-1:0] hit;

    always_comb begin
        hit = fall_i ? (prev_q & ~lvl_i) : (lvl_i & ~prev_q);
        hit = hit & ien_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            flag_q <= '0;
        end else begin
            prev_q <= lvl_i;
            flag_q <= (flag_q & ~clr_i) | hit;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pinbank_route.sv
module pinbank_route
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int NUM_PERIPH = 2,
    parameter int SIG_W      = 2,
    parameter int ALT_SHIFT  = 2,
    localparam int NSIG      = NUM_PERIPH * SIG_W
) (
    input  logic [NUM_PINS-1:0]   func_i,
    input  logic [NUM_PINS-1:0]   dout_i,
    input  logic [NUM_PINS-1:0]   dir_i,
    input  logic [NUM_PERIPH-1:0] loc_i,
    input  logic [NSIG-1:0]       per_out_i,
    input  logic [NSIG-1:0]       per_oe_i,
    input  logic [NUM_PINS-1:0]   lvl_i,
    output logic [NUM_PINS-1:0]   pad_out_o,
    output logic [NUM_PINS-1:0]   pad_oe_o,
    output logic [NSIG-1:0]       per_in_o
);
    // Scan from the highest peripheral down so the lowest one is written last.
    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            pad_out_o[i] = dout_i[i];
            pad_oe_o[i]  = dir_i[i];
            if (func_i[i]) begin
                pad_out_o[i] = 1'b0;
                pad_oe_o[i]  = 1'b0;
                for (int p = NUM_PERIPH - 1; p >= 0; p--) begin
                    for (int s = SIG_W - 1; s >= 0; s--) begin
                        if (route_pin(p, s, loc_i[p], SIG_W, ALT_SHIFT, NUM_PINS) == i) begin
                            pad_out_o[i] = per_out_i[p*SIG_W+s];
                            pad_oe_o[i]  = per_oe_i[p*SIG_W+s];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        for (int p = 0; p < NUM_PERIPH; p++) begin
            for (int s = 0; s < SIG_W; s++) begin
                per_in_o[p*SIG_W+s] = lvl_i[route_pin(p, s, loc_i[p], SIG_W, ALT_SHIFT, NUM_PINS)];
            end
        end
    end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS   = 8,
    parameter int NUM_PERIPH = 2,
    parameter int SIG_W      = 2,
    parameter int ALT_SHIFT  = 2,
    localparam int NSIG      = NUM_PERIPH * SIG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [NUM_PINS-1:0] reg_wdata_i,
    output logic [NUM_PINS-1:0] reg_rdata_o,
    input  logic [NUM_PINS-1:0] pad_in_i,
    output logic [NUM_PINS-1:0] pad_out_o,
    output logic [NUM_PINS-1:0] pad_oe_o,
    output logic [NUM_PINS-1:0] pad_pu_o,
    output logic [NUM_PINS-1:0] pad_pd_o,
    input  logic [NSIG-1:0]     per_out_i,
    input  logic [NSIG-1:0]     per_oe_i,
    output logic [NSIG-1:0]     per_in_o,
    output logic                irq_o
);
    localparam int CTRL_W = 1 + NUM_PERIPH;

    logic [NUM_PINS-1:0]   dout_q, dir_q, func_q, pen_q, psel_q, ien_q;
    logic                  fall_q;
    logic [NUM_PERIPH-1:0] loc_q;
    logic [NUM_PINS-1:0]   lvl_w, flag_w, clr_w;
    reg_addr_e             addr;

    assign addr = reg_addr_e'(reg_addr_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
            func_q <= '0;
            pen_q  <= '0;
            psel_q <= '0;
            ien_q  <= '0;
            fall_q <= 1'b0;
            loc_q  <= '0;
        end else if (reg_wr_i) begin
            unique case (addr)
                A_DOUT: dout_q <= reg_wdata_i;
                A_DIR:  dir_q  <= reg_wdata_i;
                A_FUNC: func_q <= reg_wdata_i;
                A_PEN:  pen_q  <= reg_wdata_i;
                A_PSEL: psel_q <= reg_wdata_i;
                A_IEN:  ien_q  <= reg_wdata_i;
                A_FLAG: ;
                A_CTRL: begin
                    fall_q <= reg_wdata_i[0];
                    loc_q  <= reg_wdata_i[CTRL_W-1:1];
                end
            endcase
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        unique case (addr)
            A_DOUT: reg_rdata_o = lvl_w;
            A_DIR:  reg_rdata_o = dir_q;
            A_FUNC: reg_rdata_o = func_q;
            A_PEN:  reg_rdata_o = pen_q;
            A_PSEL: reg_rdata_o = psel_q;
            A_IEN:  reg_rdata_o = ien_q;
            A_FLAG: reg_rdata_o = flag_w;
            A_CTRL: reg_rdata_o[CTRL_W-1:0] = {loc_q, fall_q};
        endcase
    end

    assign clr_w    = (reg_wr_i && addr == A_FLAG) ? reg_wdata_i : '0;
    assign pad_pu_o = pen_q & psel_q;
    assign pad_pd_o = pen_q & ~psel_q;
    assign irq_o    = |(flag_w & ien_q);

    pinbank_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pad_in_i),
        .q_o   (lvl_w)
    );

    pinbank_edge #(.W(NUM_PINS)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_w),
        .fall_i (fall_q),
        .ien_i  (ien_q),
        .clr_i  (clr_w),
        .flag_o (flag_w)
    );

    pinbank_route #(
        .NUM_PINS   (NUM_PINS),
        .NUM_PERIPH (NUM_PERIPH),
        .SIG_W      (SIG_W),
        .ALT_SHIFT  (ALT_SHIFT)
    ) u_route (
        .func_i    (func_q),
        .dout_i    (dout_q),
        .dir_i     (dir_q),
        .loc_i     (loc_q),
        .per_out_i (per_out_i),
        .per_oe_i  (per_oe_i),
        .lvl_i     (lvl_w),
        .pad_out_o (pad_out_o),
        .pad_oe_o  (pad_oe_o),
        .per_in_o  (per_in_o)
    );
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr_i,
    input logic [2:0]          reg_addr_i,
    input logic [NUM_PINS-1:0] reg_wdata_i,
    input logic [NUM_PINS-1:0] func_q,
    input logic [NUM_PINS-1:0] dir_q,
    input logic [NUM_PINS-1:0] ien_q,
    input logic [NUM_PINS-1:0] flag_w,
    input logic [NUM_PINS-1:0] pad_oe_o,
    input logic [NUM_PINS-1:0] pad_pu_o,
    input logic [NUM_PINS-1:0] pad_pd_o,
    input logic                irq_o
);
    p_pull_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu_o & pad_pd_o) == '0);

    p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((flag_w & ien_q) != '0));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        p_sw_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !func_q[i] |-> (pad_oe_o[i] == dir_q[i]));

        p_flag_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_w[i]) |-> $past(ien_q[i]));

        p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_w[i] && !(reg_wr_i && reg_addr_i == 3'd6 && reg_wdata_i[i])) |=> flag_w[i]);
    end
endmodule

bind pinbank_ctrl pinbank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .func_q      (func_q),
    .dir_q       (dir_q),
    .ien_q       (ien_q),
    .flag_w      (flag_w),
    .pad_oe_o    (pad_oe_o),
    .pad_pu_o    (pad_pu_o),
    .pad_pd_o    (pad_pd_o),
    .irq_o       (irq_o)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu, pad_pd;
    logic [3:0] per_out = '0, per_oe = '0;
    logic [3:0] per_in;
    logic       irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // shadow of what software wrote
    logic [7:0] s_dout, s_dir, s_func, s_pen, s_psel;
    logic [1:0] s_loc;

    always #10 clk = ~clk;

    pinbank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .pad_in_i(pad_in),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu), .pad_pd_o(pad_pd),
        .per_out_i(per_out), .per_oe_i(per_oe), .per_in_o(per_in), .irq_o(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int pmap(int p, int s, bit l);
        return l ? ((p * 2 + s + 2) % 8) : (p * 2 + s);
    endfunction

    // expected pad drive: software pins from shadow, peripheral pins by first (lowest) owner
    function automatic logic [15:0] m_drive();
        logic [7:0] o, e;
        for (int i = 0; i < 8; i++) begin
            bit found = 0;
            o[i] = s_func[i] ? 1'b0 : s_dout[i];
            e[i] = s_func[i] ? 1'b0 : s_dir[i];
            if (s_func[i]) begin
                for (int p = 0; p < 2 && !found; p++)
                    for (int s = 0; s < 2 && !found; s++)
                        if (pmap(p, s, s_loc[p]) == i) begin
                            found = 1;
                            o[i] = per_out[p*2+s];
                            e[i] = per_oe[p*2+s];
                        end
            end
        end
        return {e, o};
    endfunction

    function automatic logic [3:0] m_perin(logic [7:0] lv);
        logic [3:0] r;
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < 2; s++)
                r[p*2+s] = lv[pmap(p, s, s_loc[p])];
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [31:0] seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", pad_oe, 8'h00);
        chk("R1 out", pad_out, 8'h00);
        chk("R1 pulls", {pad_pu, pad_pd}, 16'h0);
        chk("R1 irq", irq, 0);
        for (int a = 1; a < 8; a++) begin
            rd(a[2:0], d);
            chk("R1 reg", d, 8'h00);
        end

        // R7 / R6 directed: peripheral 0 at location 1 overlaps peripheral 1 at location 0
        s_dout = '0; s_dir = '0; s_func = 8'hFF; s_pen = '0; s_psel = '0; s_loc = 2'b01;
        per_out = 4'b1001; per_oe = 4'b1111;
        wr(3'd2, s_func);
        wr(3'd7, {5'b0, s_loc, 1'b0});
        chk("R7 priority pins 3:2", pad_out[3:2], 2'b01);
        chk("R6 unclaimed pins undriven", pad_oe, 8'b0000_1100);

        // R3 pulls directed
        wr(3'd3, 8'hF0);
        wr(3'd4, 8'hCC);
        chk("R3 pull up", pad_pu, 8'hC0);
        chk("R3 pull down", pad_pd, 8'h30);

        // random mix: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 40; k++) begin
            s_dout = $urandom; s_dir = $urandom; s_func = $urandom;
            s_pen = $urandom; s_psel = $urandom; s_loc = $urandom;
            per_out = $urandom; per_oe = $urandom;
            wr(3'd0, s_dout); wr(3'd1, s_dir); wr(3'd2, s_func);
            wr(3'd3, s_pen); wr(3'd4, s_psel); wr(3'd7, {5'b0, s_loc, 1'b0});
            begin
                logic [15:0] ex;
                ex = m_drive();
                chk("R2 R6 R7 pad_out", pad_out, ex[7:0]);
                chk("R2 R6 R7 pad_oe", pad_oe, ex[15:8]);
            end
            chk("R3 pu", pad_pu, s_pen & s_psel);
            chk("R3 pd", pad_pd, s_pen & ~s_psel);
            pad_in = $urandom;
            @(negedge clk);
            @(negedge clk);
            rd(3'd0, d);
            chk("R4 level readback", d, pad_in);
            chk("R5 per_in", per_in, m_perin(pad_in));
        end

        // R4 latency: level not visible after one edge
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        rd(3'd0, d);
        chk("R4 one edge old", d, 8'h00);
        @(negedge clk);
        rd(3'd0, d);
        chk("R4 two edges new", d, 8'h5A);

        // R8 edge flags
        pad_in = 8'h00;
        wr(3'd7, 8'h00);
        wr(3'd5, 8'h01);
        repeat (3) @(negedge clk);
        wr(3'd6, 8'hFF);
        pad_in = 8'h03;
        @(negedge clk);
        @(negedge clk);
        rd(3'd6, d);
        chk("R8 flag not yet after two edges", d, 8'h00);
        @(negedge clk);
        rd(3'd6, d);
        chk("R8 rising sets enabled flag only", d, 8'h01);
        chk("R10 irq high", irq, 1);

        // R9 sticky / clear
        wr(3'd6, 8'h00);
        rd(3'd6, d);
        chk("R9 write 0 keeps flag", d, 8'h01);
        wr(3'd6, 8'h01);
        rd(3'd6, d);
        chk("R9 write 1 clears", d, 8'h00);
        chk("R10 irq low after clear", irq, 0);

        // R8 falling select: rising edges ignored, falling sets
        wr(3'd7, 8'h01);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        rd(3'd6, d);
        chk("R8 falling sets flag", d, 8'h01);
        wr(3'd6, 8'h01);
        pad_in = 8'h01;
        repeat (3) @(negedge clk);
        rd(3'd6, d);
        chk("R8 rising ignored in falling mode", d, 8'h00);

        // R9 edge wins over clear in same cycle
        pad_in = 8'h00;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h01;
        @(negedge clk);
        reg_wr = 1'b0;
        rd(3'd6, d);
        chk("R9 edge beats clear", d, 8'h01);

        // R10 masking by enable
        wr(3'd5, 8'h00);
        chk("R10 masked irq", irq, 0);
        rd(3'd6, d);
        chk("R10 flag kept while masked", d, 8'h01);
        wr(3'd5, 8'h01);
        chk("R10 unmask irq", irq, 1);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule